// File: doc/BRIEF.md
# Receive Flow-Control Character Detector

This block sits between a UART receiver and its receive FIFO. Every character the receiver delivers is checked against programmed resume and stop codes. A matched stop code raises a request to pause the local transmitter, and a matched resume code withdraws it. The comparison uses either single characters or ordered pairs of characters. Characters consumed as flow-control codes never reach the FIFO. All other characters are forwarded, one cycle after the strobe, on a single write port.

Several options change how matching works:
- A resume-on-anything option lets any received character end a pause.
- A special-character mode leaves flow control off and flags arrivals of the second stop code, while still storing that character.
- Every comparison looks only at the low bits selected by the programmed word length.

The pause output waits for the character currently being transmitted to finish. A status flag reports matches. Reading it clears it, and an interrupt follows the flag when enabled. Received-character strobes are expected at least two clock cycles apart, which any serial line rate easily satisfies.

Top module: `rx_flowctl_detect`

## Requirements
- R1: With `flow_mode` 0 or 3 (flow control off) and `spec_mode` low, every character strobed on `rx_valid` appears on `fifo_data` with `fifo_we` high for exactly one cycle, in the cycle after the strobe.
- R2: With `flow_mode` 1 (single), a character equal to `xoff1` is not written to the FIFO and sets `stat_flag`.
- R3: After a stop-code match, `tx_pause` rises one cycle after the internal pause request, provided `tx_busy` is low.
- R4: While `tx_busy` is high, `tx_pause` does not rise; it rises in the cycle after `tx_busy` falls if the pause request is still present.
- R5: In single mode, a character equal to `xon1` is not written to the FIFO, withdraws the pause and clears `stat_flag`.
- R6: A one-cycle `stat_rd` pulse clears `stat_flag`, except that a match in the same cycle leaves it set; `irq` is high exactly when `stat_flag` and `int_en` are both high.
- R7: With `flow_mode` 2 (double), the pair `xoff1` then `xoff2` pauses and the pair `xon1` then `xon2` resumes, and none of the four characters is written.
- R8: In double mode, when a held first character is followed by a character that does not complete its pair, the held character is written first. The new character is then held if it matches `xon1` or `xoff1`, or otherwise written one cycle after the held one.
- R9: With `xon_any` high and a pause in effect, any received character withdraws the pause, clears `stat_flag` and is written to the FIFO. A stop code received while not paused still pauses.
- R10: `wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 compared bits, counted from bit 0 (the first-received bit), and higher bits are ignored in every comparison.
- R11: With flow control off and `spec_mode` high, a character equal to `xoff2` is written to the FIFO and sets `stat_flag`, without pausing.
- R12: Switching flow control off withdraws any pause request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character, bit 0 first on the line |
| wlen | input | 2 | Word length: 0..3 selects 5..8 bits |
| flow_mode | input | 2 | 0 off, 1 single, 2 double, 3 off |
| xon_any | input | 1 | Any character ends a pause |
| spec_mode | input | 1 | Flag second-stop-code arrivals while flow control is off |
| int_en | input | 1 | Interrupt enable for the status flag |
| xon1 | input | 8 | First resume code |
| xon2 | input | 8 | Second resume code |
| xoff1 | input | 8 | First stop code |
| xoff2 | input | 8 | Second stop code, also the special character |
| tx_busy | input | 1 | Transmitter is sending a character |
| stat_rd | input | 1 | Status read strobe, clears the flag |
| fifo_we | output | 1 | Receive FIFO write enable |
| fifo_data | output | 8 | Receive FIFO write data |
| tx_pause | output | 1 | Hold the transmitter |
| stat_flag | output | 1 | Flow-control / special-character status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the double-mode partial match. A first stop code is held and then broken by an ordinary character, so two FIFO writes fall on consecutive cycles. A variant breaks the pair with another first code, which must be held rather than written. The stimulus reaches these cases by sending a stop code followed by a plain letter, then a stop code twice followed by the second stop code. A scoreboard queue carries the expected order of writes, so a reversed or lost write is caught.

// File: rtl/xf_pkg.sv
package xf_pkg;
    typedef enum logic [1:0] {
        FM_OFF    = 2'd0,
        FM_SINGLE = 2'd1,
        FM_DOUBLE = 2'd2,
        FM_OFF3   = 2'd3
    } flow_mode_e;

    localparam int IX_XON1  = 0;
    localparam int IX_XON2  = 1;
    localparam int IX_XOFF1 = 2;
    localparam int IX_XOFF2 = 3;
    localparam int NCODES   = 4;

    typedef struct packed {
        logic       pause_req;
        logic       flag;
        logic       hold_v;
        logic       hold_on;
        logic       hold_off;
        logic [7:0] hold_data;
        logic       pend;
        logic [7:0] pend_data;
        logic       we;
        logic [7:0] wdata;
    } det_state_t;
endpackage

// File: rtl/xf_match.sv
module xf_match #(
    parameter int DW  = 8,
    parameter int WLW = 2
) (
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [WLW-1:0] wlen,
    output logic           hit
);
    localparam int MINW = DW - (1 << WLW) + 1;

    logic [DW-1:0] mask;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < (MINW + int'(wlen)));
        end
        hit = (((a ^ b) & mask) == '0);
    end
endmodule

// File: rtl/xf_pause.sv
module xf_pause (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_req,
    input  logic tx_busy,
    output logic tx_pause
);
    logic pause_d, pause_q;

    always_comb begin
        pause_d = pause_req & (pause_q | ~tx_busy);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pause_q <= 1'b0;
        else        pause_q <= pause_d;
    end

    assign tx_pause = pause_q;

    // R4: the pause never starts in the middle of a transmitted character
    a_r4_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause_q && tx_busy) |=> !pause_q);

    // R3: a rising pause always follows a pause request
    a_r3_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_q) |-> $past(pause_req));
endmodule

// File: rtl/rx_flowctl_detect.sv
module rx_flowctl_detect
    import xf_pkg::*;
#(
    parameter int DW  = 8,
    parameter int WLW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_valid,
    input  logic [DW-1:0]  rx_data,
    input  logic [WLW-1:0] wlen,
    input  logic [1:0]     flow_mode,
    input  logic           xon_any,
    input  logic           spec_mode,
    input  logic           int_en,
    input  logic [DW-1:0]  xon1,
    input  logic [DW-1:0]  xon2,
    input  logic [DW-1:0]  xoff1,
    input  logic [DW-1:0]  xoff2,
    input  logic           tx_busy,
    input  logic           stat_rd,
    output logic           fifo_we,
    output logic [DW-1:0]  fifo_data,
    output logic           tx_pause,
    output logic           stat_flag,
    output logic           irq
);
    det_state_t       st_d, st_q;
    logic [NCODES-1:0] hit;
    logic [DW-1:0]     codes [NCODES];
    flow_mode_e        mode;
    logic              flow_on;
    logic              set_flag, clr_flag;

    assign codes[IX_XON1]  = xon1;
    assign codes[IX_XON2]  = xon2;
    assign codes[IX_XOFF1] = xoff1;
    assign codes[IX_XOFF2] = xoff2;

    for (genvar g = 0; g < NCODES; g++) begin : g_cmp
        xf_match #(.DW(DW), .WLW(WLW)) u_m (
            .a   (rx_data),
            .b   (codes[g]),
            .wlen(wlen),
            .hit (hit[g])
        );
    end

    assign mode    = flow_mode_e'(flow_mode);
    assign flow_on = (mode == FM_SINGLE) || (mode == FM_DOUBLE);

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        set_flag = 1'b0;
        clr_flag = 1'b0;

        if (st_q.pend) begin
            st_d.we    = 1'b1;
            st_d.wdata = st_q.pend_data;
            st_d.pend  = 1'b0;
        end
        if (mode != FM_DOUBLE) st_d.hold_v = 1'b0;

        if (!flow_on) begin
            st_d.pause_req = 1'b0;
            if (rx_valid) begin
                st_d.we    = 1'b1;
                st_d.wdata = rx_data;
                if (spec_mode && hit[IX_XOFF2]) set_flag = 1'b1;
            end
        end else if (rx_valid) begin
            if (xon_any && st_q.pause_req) begin
                st_d.pause_req = 1'b0;
                clr_flag       = 1'b1;
                st_d.we        = 1'b1;
                st_d.hold_v    = 1'b0;
                if (st_q.hold_v && mode == FM_DOUBLE) begin
                    st_d.wdata     = st_q.hold_data;
                    st_d.pend      = 1'b1;
                    st_d.pend_data = rx_data;
                end else begin
                    st_d.wdata = rx_data;
                end
            end else if (mode == FM_SINGLE) begin
                if (hit[IX_XOFF1]) begin
                    st_d.pause_req = 1'b1;
                    set_flag       = 1'b1;
                end else if (hit[IX_XON1]) begin
                    st_d.pause_req = 1'b0;
                    clr_flag       = 1'b1;
                end else begin
                    st_d.we    = 1'b1;
                    st_d.wdata = rx_data;
                end
            end else begin
                if (st_q.hold_v && st_q.hold_off && hit[IX_XOFF2]) begin
                    st_d.pause_req = 1'b1;
                    set_flag       = 1'b1;
                    st_d.hold_v    = 1'b0;
                end else if (st_q.hold_v && st_q.hold_on && hit[IX_XON2]) begin
                    st_d.pause_req = 1'b0;
                    clr_flag       = 1'b1;
                    st_d.hold_v    = 1'b0;
                end else begin
                    if (st_q.hold_v) begin
                        st_d.we    = 1'b1;
                        st_d.wdata = st_q.hold_data;
                    end
                    if (hit[IX_XOFF1] || hit[IX_XON1]) begin
                        st_d.hold_v    = 1'b1;
                        st_d.hold_data = rx_data;
                        st_d.hold_on   = hit[IX_XON1];
                        st_d.hold_off  = hit[IX_XOFF1];
                    end else begin
                        st_d.hold_v = 1'b0;
                        if (st_q.hold_v) begin
                            st_d.pend      = 1'b1;
                            st_d.pend_data = rx_data;
                        end else begin
                            st_d.we    = 1'b1;
                            st_d.wdata = rx_data;
                        end
                    end
                end
            end
        end

        if (set_flag)                 st_d.flag = 1'b1;
        else if (clr_flag || stat_rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    xf_pause u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .pause_req(st_q.pause_req),
        .tx_busy  (tx_busy),
        .tx_pause (tx_pause)
    );

    assign fifo_we   = st_q.we;
    assign fifo_data = st_q.wdata;
    assign stat_flag = st_q.flag;
    assign irq       = st_q.flag & int_en;

    // R1, R8: every FIFO write comes from a fresh strobe or a pending character
    a_r1_write_source: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> ($past(rx_valid) || $past(st_q.pend)));

    // R6: a status read with no incoming character clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_valid) |=> !st_q.flag);

    // R12: flow control off leaves no pause request behind
    a_r12_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_on |=> !st_q.pause_req);

    // R8: a pending character is always written in the next cycle
    a_r8_pend_drains: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> (st_q.we && !st_q.pend));
endmodule

// File: tb/sim_rx_flowctl_detect.sv
module sim_rx_flowctl_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [1:0] wlen = 2'd3;
    logic [1:0] flow_mode = 2'd0;
    logic       xon_any = 1'b0, spec_mode = 1'b0, int_en = 1'b0;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h12, xoff1 = 8'h13, xoff2 = 8'h14;
    logic       tx_busy = 1'b0, stat_rd = 1'b0;
    logic       fifo_we, tx_pause, stat_flag, irq;
    logic [7:0] fifo_data;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    rx_flowctl_detect u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .wlen(wlen), .flow_mode(flow_mode), .xon_any(xon_any),
        .spec_mode(spec_mode), .int_en(int_en), .xon1(xon1), .xon2(xon2),
        .xoff1(xoff1), .xoff2(xoff2), .tx_busy(tx_busy), .stat_rd(stat_rd),
        .fifo_we(fifo_we), .fifo_data(fifo_data), .tx_pause(tx_pause),
        .stat_flag(stat_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [7:0] c, input string tag);
        exp_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    // one character, then two idle cycles
    task automatic send(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd_stat();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && fifo_we) begin
            string t;
            nchk++;
            if (exp_q.size() == 0) begin
                nerr++;
                $display("FAIL R1 unexpected write actual=%0h expected=none", fifo_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (fifo_data !== e) begin
                    nerr++;
                    $display("FAIL %s fifo actual=%0h expected=%0h", t, fifo_data, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset we", fifo_we, 0);
        chk("R3 reset pause", tx_pause, 0);
        chk("R6 reset flag", stat_flag, 0);
        rst_n = 1'b1;

        // R1 pass-through, modes 0 and 3
        expect_wr(8'h41, "R1"); send(8'h41);
        expect_wr(8'h13, "R1"); send(8'h13);
        flow_mode = 2'd3;
        expect_wr(8'h11, "R1"); send(8'h11);
        chk("R1 no pause when off", tx_pause, 0);

        // R2/R3/R5 single mode
        flow_mode = 2'd1;
        send(8'h13);
        chk("R2 flag after xoff", stat_flag, 1);
        chk("R3 pause after xoff", tx_pause, 1);
        expect_wr(8'h42, "R2"); send(8'h42);
        chk("R3 still paused", tx_pause, 1);
        send(8'h11);
        chk("R5 flag cleared", stat_flag, 0);
        @(negedge clk);
        chk("R5 resumed", tx_pause, 0);

        // R4 wait for transmitter
        tx_busy = 1'b1;
        send(8'h13);
        chk("R4 held off while busy", tx_pause, 0);
        @(negedge clk);
        tx_busy = 1'b0;
        @(negedge clk);
        chk("R4 pause after busy drops", tx_pause, 1);

        // R6 flag read / irq
        int_en = 1'b0;
        chk("R6 irq masked", irq, 0);
        int_en = 1'b1;
        #0;
        chk("R6 irq enabled", irq, 1);
        rd_stat();
        chk("R6 read clears", stat_flag, 0);
        chk("R6 irq drops", irq, 0);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h13; stat_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; stat_rd = 1'b0;
        chk("R6 set wins over read", stat_flag, 1);
        send(8'h11);
        @(negedge clk);
        chk("R5 resumed again", tx_pause, 0);

        // R7 double mode
        flow_mode = 2'd2;
        send(8'h13); send(8'h14);
        chk("R7 flag", stat_flag, 1);
        chk("R7 paused", tx_pause, 1);
        expect_wr(8'h43, "R7"); send(8'h43);
        send(8'h11); send(8'h12);
        @(negedge clk);
        chk("R7 resumed", tx_pause, 0);
        chk("R7 flag cleared", stat_flag, 0);

        // R8 partial matches
        expect_wr(8'h13, "R8"); expect_wr(8'h44, "R8");
        send(8'h13); send(8'h44);
        chk("R8 not paused", tx_pause, 0);
        expect_wr(8'h13, "R8");
        send(8'h13); send(8'h13); send(8'h14);
        chk("R8 paused after rematch", tx_pause, 1);
        expect_wr(8'h13, "R8");
        send(8'h13); send(8'h11); send(8'h12);
        @(negedge clk);
        chk("R8 resumed via held xon1", tx_pause, 0);

        // R9 resume on any character
        flow_mode = 2'd1; xon_any = 1'b1;
        send(8'h13);
        chk("R9 paused", tx_pause, 1);
        expect_wr(8'h5A, "R9"); send(8'h5A);
        @(negedge clk);
        chk("R9 resumed", tx_pause, 0);
        chk("R9 flag cleared", stat_flag, 0);
        expect_wr(8'h5B, "R9"); send(8'h5B);
        send(8'h13);
        chk("R9 xoff still works", tx_pause, 1);
        xon_any = 1'b0;
        send(8'h11);
        @(negedge clk);

        // R10 word length
        wlen = 2'd0;
        send(8'hF3);
        chk("R10 5-bit match pauses", tx_pause, 1);
        wlen = 2'd3;
        expect_wr(8'h91, "R10"); send(8'h91);
        chk("R10 8-bit mismatch stays paused", tx_pause, 1);
        wlen = 2'd2;
        send(8'h91);
        @(negedge clk);
        chk("R10 7-bit match resumes", tx_pause, 0);
        wlen = 2'd3;

        // R12 disabling flow control releases pause
        send(8'h13);
        chk("R12 paused", tx_pause, 1);
        flow_mode = 2'd0;
        @(negedge clk); @(negedge clk);
        chk("R12 released", tx_pause, 0);

        // R11 special character
        rd_stat();
        spec_mode = 1'b1;
        expect_wr(8'h14, "R11"); send(8'h14);
        chk("R11 flag", stat_flag, 1);
        chk("R11 no pause", tx_pause, 0);
        rd_stat();
        expect_wr(8'h20, "R11"); send(8'h20);
        chk("R11 plain char no flag", stat_flag, 0);

        repeat (4) @(negedge clk);
        chk("R1 all expected writes seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule